// File: doc/BRIEF.md
# Shape-Converting Dual-Clock FIFO

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. It holds 4096 bits of data. Each side picks its own word shape from a 3-bit code, and the two codes need not match. Data goes in as a continuous bit stream, so a producer can push 18-bit words while a consumer pulls 4-bit words, or the other way round. Within a word, bit 0 is the earliest bit of the stream.

Each side has an active-low block enable and a data enable. The polarity of each data enable is set by a parameter. The read side can add a one-cycle output register. Two stop inputs keep the counters from running past empty or full. Status comes out as four flags: full and almost-full in the write clock domain, empty and almost-empty in the read clock domain. Each flag is computed from the opposite side's count after it passes through a synchronizer. The shape codes are static: change them only while reset is asserted.

Top module: `shape_fifo`

## Requirements
- R1: Shape code 0 moves 1-bit words, 1 moves 2-bit, 2 moves 4-bit, 3 moves 9-bit and 4 moves 18-bit words. Each accepted write appends the low `width` bits of `wData` to the stream, bit 0 first. Each accepted read removes the oldest `width` bits and presents them on `rData[width-1:0]`, oldest bit in bit 0.
- R2: A shape code of 5, 6 or 7 makes that port transfer nothing. With such a read code, `rEmpty` stays high and `rData` keeps its value.
- R3: Bits of `wData` at or above the write width are not stored.
- R4: `wBlkN` and `rBlkN` are active low. While `rBlkN` is high, `rData` holds its value and no read is taken.
- R5: With the default parameters, a write needs `wEn` = 0 and a read needs `rEn` = 1. The opposite level on either pin is ignored.
- R6: With `rPipe` = 0, read data shows on `rData` after the read clock edge that takes the read. With `rPipe` = 1, it shows one read-clock edge later.
- R7: While `rstN` is low, `rData` is zero, `rEmpty` and `rAempty` are high, and `wFull` and `wAfull` are low.
- R8: `rEmpty` is high when fewer bits than the read width are stored. A read while empty leaves `rData` unchanged. With `eStop` high, the read counter does not move while empty.
- R9: `wFull` is high when fewer free bits than the write width remain. With `fStop` high, a write while full is dropped and the write counter does not move.
- R10: `wAfull` is high when the free bits are fewer than the write width plus `AF_BITS`. `rAempty` is high when the stored bits are fewer than the read width plus `AE_BITS`.
- R11: A transfer on one side reaches the other side's flags within a few cycles of that side's clock, through `SYNC_STAGES` synchronizer flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wClk | input | 1 | Write-side clock |
| rClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low, shared by both sides |
| wShape | input | 3 | Write word shape code |
| rShape | input | 3 | Read word shape code |
| wBlkN | input | 1 | Write port enable, active low |
| rBlkN | input | 1 | Read port enable, active low; output holds while high |
| wEn | input | 1 | Write data enable (polarity set by parameter) |
| rEn | input | 1 | Read data enable (polarity set by parameter) |
| wData | input | 18 | Write word, low bits used |
| rPipe | input | 1 | 1 adds one cycle of read latency |
| eStop | input | 1 | Freeze read counter while empty |
| fStop | input | 1 | Freeze write counter while full |
| rData | output | 18 | Read word, low bits valid |
| wFull | output | 1 | No room for one write word |
| wAfull | output | 1 | Free space below write width plus threshold |
| rEmpty | output | 1 | Less than one read word stored |
| rAempty | output | 1 | Stored bits below read width plus threshold |

## Verification
Some behaviours are checked on every cycle by properties. Each pointer moves only by its own port's width. Both counters stay frozen at the stop conditions. `rData` stays still while the read port is disabled and after an edge on which the FIFO was empty. Other behaviours only the bench's scenarios can show. These are bit-exact width conversion across all shapes and wrap-around of the array, the exact cycle at which pipelined and direct reads appear, the flag thresholds at every fill level, the effect of reserved codes and of inactive enable levels, and the reset values.

// File: rtl/shape_fifo_pkg.sv
`timescale 1ns/1ps
package shape_fifo_pkg;
  localparam int BUS_W = 18;
  localparam int WID_W = 5;

  typedef struct packed {
    logic             load;
    logic [WID_W-1:0] width;
  } portStb_t;

  typedef struct packed {
    portStb_t wr;
    portStb_t rd;
  } fifoStb_t;

  function automatic logic [WID_W-1:0] shapeWidth(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd9;
      3'd4:    return 5'd18;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/shape_fifo_sync.sv
`timescale 1ns/1ps
module shape_fifo_sync #(
  parameter int W      = 13,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] flop [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) flop[0] <= '0;
        else       flop[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) flop[s] <= '0;
        else       flop[s] <= flop[s-1];
    end
  end

  assign q = flop[STAGES-1];
endmodule

// File: rtl/shape_fifo_ctrl.sv
`timescale 1ns/1ps
module shape_fifo_ctrl
  import shape_fifo_pkg::*;
#(
  parameter int CAP_LOG2    = 12,
  parameter int AF_BITS     = 64,
  parameter int AE_BITS     = 64,
  parameter int SYNC_STAGES = 2,
  parameter bit WEN_HIGH    = 1'b0,
  parameter bit REN_HIGH    = 1'b1
) (
  input  logic                wClk,
  input  logic                rClk,
  input  logic                rstN,
  input  logic [2:0]          wShape,
  input  logic [2:0]          rShape,
  input  logic                wBlkN,
  input  logic                rBlkN,
  input  logic                wEn,
  input  logic                rEn,
  input  logic                eStop,
  input  logic                fStop,
  output fifoStb_t            stb,
  output logic [CAP_LOG2-1:0] wAddr,
  output logic [CAP_LOG2-1:0] rAddr,
  output logic [CAP_LOG2:0]   wPtr,
  output logic [CAP_LOG2:0]   rPtr,
  output logic                wFull,
  output logic                wAfull,
  output logic                rEmpty,
  output logic                rAempty
);
  localparam int AW = CAP_LOG2;
  localparam int PW = CAP_LOG2 + 1;
  localparam logic [PW-1:0] CAP_BITS = {1'b1, {AW{1'b0}}};
  localparam logic [PW-1:0] AF_P     = PW'(AF_BITS);
  localparam logic [PW-1:0] AE_P     = PW'(AE_BITS);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WID_W-1:0] wWid, rWid;
  logic [PW-1:0]    wWidX, rWidX;
  logic             wValid, rValid, wEnOn, rEnOn;

  assign wWid   = shapeWidth(wShape);
  assign rWid   = shapeWidth(rShape);
  assign wWidX  = PW'(wWid);
  assign rWidX  = PW'(rWid);
  assign wValid = (wWid != '0);
  assign rValid = (rWid != '0);
  assign wEnOn  = WEN_HIGH ? wEn : ~wEn;
  assign rEnOn  = REN_HIGH ? rEn : ~rEn;

  // write domain
  logic [PW-1:0] wCnt, wBits, wGray, rGrayW, rCntW, rBitsW, occW, freeW;
  logic          wAcc;

  shape_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_syncR2W (
    .clk(wClk), .rstN(rstN), .d(rGray), .q(rGrayW));

  assign rCntW  = fromGray(rGrayW);
  assign rBitsW = rCntW * rWidX;
  assign occW   = wBits - rBitsW;
  assign freeW  = CAP_BITS - occW;
  assign wFull  = wValid && (freeW < wWidX);
  assign wAfull = wValid && (freeW < wWidX + AF_P);
  assign wAcc   = !wBlkN && wEnOn && wValid && !(wFull && fStop);

  always_ff @(posedge wClk or negedge rstN)
    if (!rstN) begin
      wCnt  <= '0;
      wBits <= '0;
      wGray <= '0;
    end else if (wAcc) begin
      wCnt  <= wCnt + 1'b1;
      wBits <= wBits + wWidX;
      wGray <= toGray(wCnt + 1'b1);
    end

  // read domain
  logic [PW-1:0] rCnt, rBits, rGray, wGrayR, wCntR, wBitsR, occR;
  logic          rAcc;

  shape_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_syncW2R (
    .clk(rClk), .rstN(rstN), .d(wGray), .q(wGrayR));

  assign wCntR   = fromGray(wGrayR);
  assign wBitsR  = wCntR * wWidX;
  assign occR    = wBitsR - rBits;
  assign rEmpty  = !rValid || (occR < rWidX);
  assign rAempty = !rValid || (occR < rWidX + AE_P);
  assign rAcc    = !rBlkN && rEnOn && rValid && !(rEmpty && eStop);

  always_ff @(posedge rClk or negedge rstN)
    if (!rstN) begin
      rCnt  <= '0;
      rBits <= '0;
      rGray <= '0;
    end else if (rAcc) begin
      rCnt  <= rCnt + 1'b1;
      rBits <= rBits + rWidX;
      rGray <= toGray(rCnt + 1'b1);
    end

  assign stb.wr.load  = wAcc;
  assign stb.wr.width = wWid;
  assign stb.rd.load  = rAcc && !rEmpty;
  assign stb.rd.width = rWid;
  assign wAddr = wBits[AW-1:0];
  assign rAddr = rBits[AW-1:0];
  assign wPtr  = wBits;
  assign rPtr  = rBits;
endmodule

// File: rtl/shape_fifo_dpath.sv
`timescale 1ns/1ps
module shape_fifo_dpath
  import shape_fifo_pkg::*;
#(
  parameter int CAP_LOG2 = 12
) (
  input  logic                wClk,
  input  logic                rClk,
  input  logic                rstN,
  input  fifoStb_t            stb,
  input  logic [CAP_LOG2-1:0] wAddr,
  input  logic [CAP_LOG2-1:0] rAddr,
  input  logic [BUS_W-1:0]    wData,
  input  logic                rPipe,
  input  logic                rBlkN,
  output logic [BUS_W-1:0]    rData
);
  localparam int AW  = CAP_LOG2;
  localparam int CAP = 1 << CAP_LOG2;

  logic             bitMem [CAP];
  logic [BUS_W-1:0] fetched, stageA, stageB;

  always_ff @(posedge wClk)
    for (int i = 0; i < BUS_W; i++)
      if (stb.wr.load && (i < int'(stb.wr.width)))
        bitMem[wAddr + AW'(i)] <= wData[i];

  always_comb begin
    logic [AW-1:0] idx;
    for (int i = 0; i < BUS_W; i++) begin
      idx        = rAddr + AW'(i);
      fetched[i] = (i < int'(stb.rd.width)) ? bitMem[idx] : 1'b0;
    end
  end

  always_ff @(posedge rClk or negedge rstN)
    if (!rstN) begin
      stageA <= '0;
      stageB <= '0;
    end else begin
      if (stb.rd.load) stageA <= fetched;
      if (!rBlkN)      stageB <= stageA;
    end

  assign rData = rPipe ? stageB : stageA;
endmodule

// File: rtl/shape_fifo.sv
`timescale 1ns/1ps
module shape_fifo
  import shape_fifo_pkg::*;
#(
  parameter int CAP_LOG2    = 12,
  parameter int AF_BITS     = 64,
  parameter int AE_BITS     = 64,
  parameter int SYNC_STAGES = 2,
  parameter bit WEN_HIGH    = 1'b0,
  parameter bit REN_HIGH    = 1'b1
) (
  input  logic        wClk,
  input  logic        rClk,
  input  logic        rstN,
  input  logic [2:0]  wShape,
  input  logic [2:0]  rShape,
  input  logic        wBlkN,
  input  logic        rBlkN,
  input  logic        wEn,
  input  logic        rEn,
  input  logic [17:0] wData,
  input  logic        rPipe,
  input  logic        eStop,
  input  logic        fStop,
  output logic [17:0] rData,
  output logic        wFull,
  output logic        wAfull,
  output logic        rEmpty,
  output logic        rAempty
);
  fifoStb_t              stb;
  logic [CAP_LOG2-1:0]   wAddr, rAddr;
  logic [CAP_LOG2:0]     wPtrBits, rPtrBits;

  shape_fifo_ctrl #(
    .CAP_LOG2(CAP_LOG2), .AF_BITS(AF_BITS), .AE_BITS(AE_BITS),
    .SYNC_STAGES(SYNC_STAGES), .WEN_HIGH(WEN_HIGH), .REN_HIGH(REN_HIGH)
  ) u_ctrl (
    .wClk(wClk), .rClk(rClk), .rstN(rstN),
    .wShape(wShape), .rShape(rShape),
    .wBlkN(wBlkN), .rBlkN(rBlkN), .wEn(wEn), .rEn(rEn),
    .eStop(eStop), .fStop(fStop),
    .stb(stb), .wAddr(wAddr), .rAddr(rAddr),
    .wPtr(wPtrBits), .rPtr(rPtrBits),
    .wFull(wFull), .wAfull(wAfull), .rEmpty(rEmpty), .rAempty(rAempty)
  );

  shape_fifo_dpath #(.CAP_LOG2(CAP_LOG2)) u_dpath (
    .wClk(wClk), .rClk(rClk), .rstN(rstN),
    .stb(stb), .wAddr(wAddr), .rAddr(rAddr),
    .wData(wData), .rPipe(rPipe), .rBlkN(rBlkN), .rData(rData)
  );
endmodule

// File: rtl/shape_fifo_chk.sv
`timescale 1ns/1ps
module shape_fifo_chk
  import shape_fifo_pkg::*;
#(
  parameter int PW = 13
) (
  input logic          wClk,
  input logic          rClk,
  input logic          rstN,
  input logic [2:0]    wShape,
  input logic          rBlkN,
  input logic          rPipe,
  input logic          eStop,
  input logic          fStop,
  input logic          wFull,
  input logic          rEmpty,
  input logic [17:0]   rData,
  input logic [PW-1:0] wPtr,
  input logic [PW-1:0] rPtr
);
  // R1: the write pointer only ever steps by the current write width
  p_wptr_step_r1: assert property (@(posedge wClk) disable iff (!rstN)
    !$stable(wPtr) |-> ((wPtr - $past(wPtr)) == PW'(shapeWidth($past(wShape)))));

  // R4: output frozen while the read port is disabled
  p_block_hold_r4: assert property (@(posedge rClk) disable iff (!rstN)
    ($past(rBlkN) && $stable(rPipe)) |-> $stable(rData));

  // R8: a direct-mode output never moves after an edge taken while empty
  p_empty_hold_r8: assert property (@(posedge rClk) disable iff (!rstN)
    ($past(rEmpty) && $past(!rPipe) && !rPipe) |-> $stable(rData));

  // R8: read counter frozen at empty when stop is requested
  p_rptr_freeze_r8: assert property (@(posedge rClk) disable iff (!rstN)
    (eStop && rEmpty) |=> $stable(rPtr));

  // R9: write counter frozen at full when stop is requested
  p_wptr_freeze_r9: assert property (@(posedge wClk) disable iff (!rstN)
    (fStop && wFull) |=> $stable(wPtr));
endmodule

bind shape_fifo shape_fifo_chk #(.PW(CAP_LOG2 + 1)) u_chk (
  .wClk(wClk), .rClk(rClk), .rstN(rstN), .wShape(wShape),
  .rBlkN(rBlkN), .rPipe(rPipe), .eStop(eStop), .fStop(fStop),
  .wFull(wFull), .rEmpty(rEmpty), .rData(rData),
  .wPtr(wPtrBits), .rPtr(rPtrBits)
);

// File: tb/tb_shape_fifo.sv
`timescale 1ns/1ps
module tb_shape_fifo;
  localparam int CAP = 4096;
  localparam int AF  = 64;
  localparam int AE  = 64;

  logic wClk = 1'b0, rClk = 1'b0;
  always #4   wClk = ~wClk;
  always #6.5 rClk = ~rClk;

  logic        rstN;
  logic [2:0]  wShape, rShape;
  logic        wBlkN, rBlkN, wEn, rEn, rPipe, eStop, fStop;
  logic [17:0] wData, rData;
  logic        wFull, wAfull, rEmpty, rAempty;

  int checks = 0;
  int fails  = 0;
  bit model[$];
  logic [17:0] lastOut;
  bit done = 1'b0;

  shape_fifo dut (
    .wClk(wClk), .rClk(rClk), .rstN(rstN), .wShape(wShape), .rShape(rShape),
    .wBlkN(wBlkN), .rBlkN(rBlkN), .wEn(wEn), .rEn(rEn), .wData(wData),
    .rPipe(rPipe), .eStop(eStop), .fStop(fStop), .rData(rData),
    .wFull(wFull), .wAfull(wAfull), .rEmpty(rEmpty), .rAempty(rAempty));

  function automatic int widthOf(input logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 9;
      3'd4: return 18;
      default: return 0;
    endcase
  endfunction

  function automatic logic [17:0] maskOf(input int w);
    return (w == 0) ? 18'd0 : 18'((32'd1 << w) - 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] ws, input logic [2:0] rs);
    wEn = 1'b1; rEn = 1'b0; wBlkN = 1'b0; rBlkN = 1'b0;
    eStop = 1'b1; fStop = 1'b1; rPipe = 1'b0; wData = '0;
    wShape = ws; rShape = rs;
    rstN = 1'b0;
    #1;
    // R7: values while reset is held
    chk(rData == 18'd0, "R7 rData cleared", int'(rData), 0);
    chk(rEmpty == 1'b1, "R7 empty high", int'(rEmpty), 1);
    chk(rAempty == 1'b1, "R7 almost-empty high", int'(rAempty), 1);
    chk(wFull == 1'b0, "R7 full low", int'(wFull), 0);
    chk(wAfull == 1'b0, "R7 almost-full low", int'(wAfull), 0);
    repeat (3) @(negedge wClk);
    rstN = 1'b1;
    model.delete();
    lastOut = '0;
    repeat (2) @(negedge rClk);
    @(negedge wClk);
  endtask

  // Writes up to n words, stopping at full; upper data bits random (R3).
  task automatic fill(input int n);
    int ww = widthOf(wShape);
    int cnt = 0;
    forever begin
      int freeBits;
      logic [31:0] d;
      @(negedge wClk);
      wEn = 1'b1;
      freeBits = CAP - model.size();
      chk(wFull == (freeBits < ww), "R9 full flag", int'(wFull), int'(freeBits < ww));
      chk(wAfull == (freeBits < ww + AF), "R10 almost-full flag", int'(wAfull), int'(freeBits < ww + AF));
      if (freeBits < ww || cnt >= n) break;
      d = $urandom;
      wData = d[17:0];
      wEn = 1'b0;
      @(posedge wClk);
      for (int i = 0; i < ww; i++) model.push_back(d[i]);
      cnt++;
    end
    wEn = 1'b1;
  endtask

  task automatic overflowTry();
    @(negedge wClk);
    wData = 18'h3FFFF; wEn = 1'b0;
    @(negedge wClk);
    wEn = 1'b1;
    chk(wFull == 1'b1, "R9 full after dropped write", int'(wFull), 1);
  endtask

  task automatic drain(input bit pipe, input int holdAt);
    int rw = widthOf(rShape);
    logic [17:0] mk = maskOf(rw);
    int k = 0;
    rPipe = pipe;
    repeat (12) @(negedge rClk);
    chk(rEmpty == (model.size() < rw), "R11 empty after crossing", int'(rEmpty), int'(model.size() < rw));
    forever begin
      logic [17:0] e;
      @(negedge rClk);
      chk(rEmpty == (model.size() < rw), "R8 empty flag", int'(rEmpty), int'(model.size() < rw));
      chk(rAempty == (model.size() < rw + AE), "R10 almost-empty flag", int'(rAempty), int'(model.size() < rw + AE));
      if (model.size() < rw) break;
      if (k == holdAt) begin
        rBlkN = 1'b1; rEn = 1'b1;
        @(negedge rClk);
        rEn = 1'b0; rBlkN = 1'b0;
        @(negedge rClk);
        chk((rData & mk) == lastOut, "R4 hold while blocked", int'(rData & mk), int'(lastOut));
      end
      rEn = 1'b1;
      @(posedge rClk);
      e = '0;
      for (int i = 0; i < rw; i++) e[i] = model.pop_front();
      @(negedge rClk);
      rEn = 1'b0;
      if (pipe) begin
        // R6: pipelined data not visible yet
        chk((rData & mk) == lastOut, "R6 pipelined latency", int'(rData & mk), int'(lastOut));
        @(negedge rClk);
      end
      chk((rData & mk) == e, "R1/R3/R6 read word", int'(rData & mk), int'(e));
      lastOut = e;
      k++;
    end
    rEn = 1'b1;
    @(negedge rClk);
    rEn = 1'b0;
    @(negedge rClk);
    @(negedge rClk);
    chk((rData & mk) == lastOut, "R8 read while empty", int'(rData & mk), int'(lastOut));
    chk(rEmpty == 1'b1, "R8 still empty", int'(rEmpty), 1);
  endtask

  initial begin
    // width conversion sweeps
    doReset(3'd4, 3'd2); fill(100000); overflowTry(); drain(1'b0, 3);
    doReset(3'd0, 3'd3); fill(100000); drain(1'b1, 5);
    doReset(3'd3, 3'd4); fill(300);    drain(1'b1, 2);
    doReset(3'd1, 3'd0); fill(100000); drain(1'b0, 7);
    doReset(3'd2, 3'd2); fill(100000); drain(1'b1, 1);
    doReset(3'd4, 3'd1); fill(700);    drain(1'b0, 0);

    // R2: reserved write shape
    doReset(3'd5, 3'd2);
    repeat (5) begin @(negedge wClk); wData = 18'h2AAAA; wEn = 1'b0; end
    @(negedge wClk); wEn = 1'b1;
    repeat (12) @(negedge rClk);
    chk(rEmpty == 1'b1, "R2 reserved write shape stores nothing", int'(rEmpty), 1);
    chk(wFull == 1'b0, "R2 reserved write shape not full", int'(wFull), 0);

    // R2: reserved read shape
    doReset(3'd2, 3'd6);
    fill(4);
    repeat (12) @(negedge rClk);
    rEn = 1'b1;
    repeat (3) @(negedge rClk);
    rEn = 1'b0;
    @(negedge rClk);
    chk(rData == 18'd0, "R2 reserved read shape output", int'(rData), 0);
    chk(rEmpty == 1'b1, "R2 reserved read shape empty", int'(rEmpty), 1);

    // R5 / R4: inactive write levels
    doReset(3'd2, 3'd2);
    repeat (4) begin @(negedge wClk); wData = 18'h0000F; wEn = 1'b1; end
    wBlkN = 1'b1;
    repeat (4) begin @(negedge wClk); wEn = 1'b0; end
    @(negedge wClk); wEn = 1'b1; wBlkN = 1'b0;
    repeat (12) @(negedge rClk);
    chk(rEmpty == 1'b1, "R5 write enable high ignored", int'(rEmpty), 1);
    chk(rEmpty == 1'b1, "R4 write port disabled ignored", int'(rEmpty), 1);
    fill(1);
    repeat (12) @(negedge rClk);
    rEn = 1'b0;
    repeat (3) @(negedge rClk);
    chk(rData == 18'd0, "R5 read enable low ignored", int'(rData), 0);
    chk(rEmpty == 1'b0, "R5 data still stored", int'(rEmpty), 0);
    drain(1'b0, -1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge wClk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule